// File: doc/BRIEF.md
# Paging Unit Control Register File

This block is the byte-wide control register file of a paging unit, reached through an 8-bit register offset. It keeps four page-table base registers, one per quarter of the virtual address space. Each has its own enable flag. It also keeps a 12-bit page index for clearing one translation-cache slot, a global translation enable, and a fixed 16-bit card identifier that can be read.

The translation datapath takes the quarter bases, the quarter enables and the global enable from the output ports. The translation cache takes two kinds of invalidation command:
- A write to a quarter's enable byte starts a flush of that quarter's 1024 slots.
- A write to the trigger byte clears the single slot named by the held index.

Reads decode the offset combinationally. An offset that the block does not decode gives no response, and a write to it is dropped.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset, every quarter base is zero, every quarter enable is 0, translation is off and the slot index is zero. No flush or clear pulse is present.
- R2: Offsets 0x00 to 0x0F form four groups of 4 bytes, and group g = offset/4. A write to group byte 0 stores the data as base bits 31:24, and a write to byte 1 stores it as bits 23:16. Reading bytes 0, 1 and 2 returns base bits 31:24, 23:16 and 15:8.
- R3: A write to group byte 2 keeps only data bits 7:4, as base bits 15:12. Base bits 11:0 always read as zero, so every base is 4 KiB aligned.
- R4: A write to group byte 3 loads the quarter enable from data bit 0. Reading that byte returns 0x00 or 0x01. On the cycle after the write, flush_start is high for one cycle with flush_quarter = g, even when the enable value does not change.
- R5: A write to 0x11 loads slot index bits 11:4. A write to 0x12 loads bits 3:0 from data bits 7:4. A write to 0x10 leaves the index unchanged.
- R6: Any write to 0x13 gives slot_clr high for one cycle on the next cycle, and slot_idx still holds the stored index.
- R7: A write to 0x15 loads xlate_en from data bit 0.
- R8: Offset 0xFE reads CARD_ID bits 15:8 and offset 0xFF reads bits 7:0, with reg_rvalid high.
- R9: Every other offset, including 0x10 to 0x15, reads with reg_rvalid low and reg_rdata zero. A write to 0x14, to 0x16 through 0xFD or to 0xFE/0xFF changes nothing.
- R10: A register write becomes visible only after the clock edge that samples it. flush_start and slot_clr each stay high for exactly one cycle per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the offset and data on this cycle |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| reg_rvalid | output | 1 | High when reg_addr is a readable offset |
| xlate_en | output | 1 | Global translation enable |
| q_enable | output | 4 | Per-quarter table enable |
| q_base | output | 128 | Quarter table bases, quarter g at bits 32g+31:32g |
| flush_start | output | 1 | One-cycle pulse: flush one quarter of the cache |
| flush_quarter | output | 2 | Quarter to flush, valid with flush_start |
| slot_clr | output | 1 | One-cycle pulse: clear one cache slot |
| slot_idx | output | 12 | Page index of the slot to clear |

## Verification
A behavioural model follows each write, and every port is compared with it on every cycle.
- Directed writes fill each quarter byte with distinct patterns. Writing 0xFF to byte 2 shows whether the low nibble is masked.
- Repeated writes of the same enable value show that a flush starts whatever the value.
- A write to 0x10 placed between the index bytes shows whether that byte is truly ignored.
- A full sweep of reads over all 256 offsets separates the identifier bytes and quarter bytes from offsets that must stay silent.
- A long run of random writes and reads, including back-to-back writes to neighbouring offsets, looks for decode overlap.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_Q     = 4;
    localparam int QSEL_W    = $clog2(NUM_Q);
    localparam int BASE_W    = 32;
    localparam int PAGE_SH   = 12;
    localparam int BHI_W     = BASE_W - PAGE_SH;   // stored base bits 31:12
    localparam int PAGE_W    = 12;
    localparam int GRP_SH    = 2;                   // 4 bytes per group
    localparam logic [ADDR_W-1:0] Q_END    = ADDR_W'(NUM_Q << GRP_SH);
    localparam logic [ADDR_W-1:0] INV_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] GEN_OFF  = 8'h15;
    localparam logic [ADDR_W-1:0] ID_HI    = 8'hFE;
    localparam logic [ADDR_W-1:0] ID_LO    = 8'hFF;

    typedef struct packed {
        logic [BHI_W-1:0] base;
        logic             en;
        logic             flush;
    } quarter_t;

    typedef struct packed {
        logic [PAGE_W-1:0] idx;
        logic              clr;
    } inval_t;

    typedef struct packed {
        logic xlate;
    } glob_t;
endpackage

// File: rtl/mmu_quarter_reg.sv
module mmu_quarter_reg
    import mmu_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic [1:0]           byte_sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [BHI_W-1:0]     base_hi,
    output logic                 en,
    output logic                 flush
);
    quarter_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (wr_hit) begin
            unique case (byte_sel)
                2'd0: st_d.base[BHI_W-1 -: 8] = wdata;
                2'd1: st_d.base[BHI_W-9 -: 8] = wdata;
                2'd2: st_d.base[3:0]          = wdata[7:4];
                2'd3: begin
                    st_d.en    = wdata[0];
                    st_d.flush = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_hi = st_q.base;
    assign en      = st_q.en;
    assign flush   = st_q.flush;

    p_flush_on_enable_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && byte_sel == 2'd3) |=> (flush && en == $past(wdata[0])));
    p_flush_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(wr_hit && byte_sel == 2'd3));
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(base_hi) && $stable(en)));
    p_low_byte_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && byte_sel == 2'd2) |=> (base_hi[3:0] == $past(wdata[7:4])));
endmodule

// File: rtl/mmu_slot_inval.sv
module mmu_slot_inval
    import mmu_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic [1:0]           byte_sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [PAGE_W-1:0]    idx,
    output logic                 clr
);
    inval_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (wr_hit) begin
            unique case (byte_sel)
                2'd0: ;
                2'd1: st_d.idx[PAGE_W-1:4] = wdata;
                2'd2: st_d.idx[3:0]        = wdata[7:4];
                2'd3: st_d.clr             = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
    assign clr = st_q.clr;

    p_clear_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && byte_sel == 2'd3) |=> (clr && $stable(idx)));
    p_pad_byte_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && byte_sel == 2'd0) |=> $stable(idx));
    p_clear_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> $past(wr_hit && byte_sel == 2'd3));
endmodule

// File: rtl/mmu_read_mux.sv
module mmu_read_mux
    import mmu_regs_pkg::*;
#(
    parameter logic [15:0] CARD_ID = 16'hA5C3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NUM_Q*BHI_W-1:0] base_flat,
    input  logic [NUM_Q-1:0]       en,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rvalid
);
    logic [QSEL_W-1:0] grp;
    logic [BHI_W-1:0]  sel_base;
    assign grp      = addr[GRP_SH +: QSEL_W];
    assign sel_base = base_flat[grp*BHI_W +: BHI_W];

    always_comb begin
        rdata  = '0;
        rvalid = 1'b0;
        if (addr < Q_END) begin
            rvalid = 1'b1;
            unique case (addr[1:0])
                2'd0: rdata = sel_base[BHI_W-1 -: 8];
                2'd1: rdata = sel_base[BHI_W-9 -: 8];
                2'd2: rdata = {sel_base[3:0], 4'h0};
                2'd3: rdata = {7'd0, en[grp]};
                default: ;
            endcase
        end else if (addr == ID_HI) begin
            rvalid = 1'b1;
            rdata  = CARD_ID[15:8];
        end else if (addr == ID_LO) begin
            rvalid = 1'b1;
            rdata  = CARD_ID[7:0];
        end
    end

    always_comb begin
        p_silent_no_data_r9: assert (rvalid || rdata == '0);
    end
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
    import mmu_regs_pkg::*;
#(
    parameter logic [15:0] CARD_ID = 16'hA5C3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [7:0]              reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    output logic                    reg_rvalid,
    output logic                    xlate_en,
    output logic [3:0]              q_enable,
    output logic [127:0]            q_base,
    output logic                    flush_start,
    output logic [1:0]              flush_quarter,
    output logic                    slot_clr,
    output logic [11:0]             slot_idx
);
    logic [NUM_Q-1:0]       q_hit;
    logic [NUM_Q-1:0]       q_flush;
    logic [NUM_Q*BHI_W-1:0] base_flat;
    logic                   inv_hit;
    glob_t                  g_d, g_q;

    assign inv_hit = reg_wr && (reg_addr[ADDR_W-1:GRP_SH] == INV_BASE[ADDR_W-1:GRP_SH]);

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_quarter
        assign q_hit[gi] = reg_wr && (reg_addr < Q_END)
                           && (reg_addr[GRP_SH +: QSEL_W] == QSEL_W'(gi));
        mmu_quarter_reg u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (q_hit[gi]),
            .byte_sel (reg_addr[1:0]),
            .wdata    (reg_wdata),
            .base_hi  (base_flat[gi*BHI_W +: BHI_W]),
            .en       (q_enable[gi]),
            .flush    (q_flush[gi])
        );
        assign q_base[gi*BASE_W +: BASE_W] = {base_flat[gi*BHI_W +: BHI_W], {PAGE_SH{1'b0}}};
    end

    mmu_slot_inval u_inv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (inv_hit),
        .byte_sel (reg_addr[1:0]),
        .wdata    (reg_wdata),
        .idx      (slot_idx),
        .clr      (slot_clr)
    );

    mmu_read_mux #(.CARD_ID(CARD_ID)) u_rd (
        .addr      (reg_addr),
        .base_flat (base_flat),
        .en        (q_enable),
        .rdata     (reg_rdata),
        .rvalid    (reg_rvalid)
    );

    always_comb begin
        g_d = g_q;
        if (reg_wr && reg_addr == GEN_OFF) g_d.xlate = reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign xlate_en = g_q.xlate;

    always_comb begin
        flush_quarter = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (q_flush[i]) flush_quarter = QSEL_W'(i);
    end
    assign flush_start = |q_flush;

    p_global_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == GEN_OFF) |=> (xlate_en == $past(reg_wdata[0])));
    p_single_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_flush));
    p_flush_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr < Q_END && reg_addr[1:0] == 2'd3)
        |=> (flush_start && flush_quarter == $past(reg_addr[3:2])));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (!flush_start && !slot_clr && $stable(xlate_en) && $stable(q_base)));
endmodule

// File: tb/mmu_ctrl_regs_test.sv
module mmu_ctrl_regs_test;
    localparam logic [15:0] ID = 16'h5E71;

    logic         clk = 0, rst_n = 0, reg_wr = 0;
    logic [7:0]   reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic         reg_rvalid, xlate_en, flush_start, slot_clr;
    logic [3:0]   q_enable;
    logic [127:0] q_base;
    logic [1:0]   flush_quarter;
    logic [11:0]  slot_idx;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0, mon_on = 0;

    always #10 clk = ~clk;

    mmu_ctrl_regs #(.CARD_ID(ID)) uut (.*);

    // behavioural reference
    logic [31:0] m_base [4];
    logic [3:0]  m_en;
    logic        m_x, m_fl, m_clr;
    logic [1:0]  m_fq;
    logic [11:0] m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_base[i] <= 0;
            m_en <= 0; m_x <= 0; m_fl <= 0; m_clr <= 0; m_fq <= 0; m_idx <= 0;
        end else begin
            m_fl <= 0; m_clr <= 0;
            if (reg_wr) begin
                int g;
                g = reg_addr / 4;
                if (reg_addr < 16) begin
                    case (reg_addr % 4)
                        0: m_base[g][31:24] <= reg_wdata;
                        1: m_base[g][23:16] <= reg_wdata;
                        2: m_base[g][15:8]  <= reg_wdata & 8'hF0;
                        default: begin m_en[g] <= reg_wdata[0]; m_fl <= 1; m_fq <= 2'(g); end
                    endcase
                end else if (reg_addr == 8'h11) m_idx[11:4] <= reg_wdata;
                else if (reg_addr == 8'h12) m_idx[3:0] <= reg_wdata[7:4];
                else if (reg_addr == 8'h13) m_clr <= 1;
                else if (reg_addr == 8'h15) m_x <= reg_wdata[0];
            end
        end
    end

    function automatic logic [8:0] exp_read(input logic [7:0] a);
        int g;
        g = a / 4;
        if (a < 16) begin
            case (a % 4)
                0: return {1'b1, m_base[g][31:24]};
                1: return {1'b1, m_base[g][23:16]};
                2: return {1'b1, m_base[g][15:8]};
                default: return {1'b1, 7'd0, m_en[g]};
            endcase
        end
        if (a == 8'hFE) return {1'b1, ID[15:8]};
        if (a == 8'hFF) return {1'b1, ID[7:0]};
        return 9'd0;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, 2 ns after the drive edge
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            logic [8:0] er;
            er = exp_read(reg_addr);
            chk("R2 R3 base", q_base, {m_base[3], m_base[2], m_base[1], m_base[0]});
            chk("R4 enable", q_enable, m_en);
            chk("R4 R10 flush_start", flush_start, m_fl);
            if (m_fl) chk("R4 flush_quarter", flush_quarter, m_fq);
            chk("R5 slot_idx", slot_idx, m_idx);
            chk("R6 R10 slot_clr", slot_clr, m_clr);
            chk("R7 xlate_en", xlate_en, m_x);
            if (reg_addr >= 8'hFE)     chk("R8 id read", {reg_rvalid, reg_rdata}, er);
            else if (reg_addr < 8'h10) chk("R2 R4 group read", {reg_rvalid, reg_rdata}, er);
            else                        chk("R9 silent read", {reg_rvalid, reg_rdata}, er);
        end
    end

    task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #3;
        // R1: reset state
        chk("R1 reset", {q_base, q_enable, xlate_en, slot_idx, flush_start, slot_clr}, '0);
        mon_on = 1;

        // R2/R3: fill quarters with distinct patterns
        for (int g = 0; g < 4; g++) begin
            cyc(1, 8'(4*g),   8'(8'h12 + 8'h31*g));
            cyc(1, 8'(4*g+1), 8'(8'hC4 ^ 8'(g)));
            cyc(1, 8'(4*g+2), 8'hFF);
        end
        cyc(0, 8'h06, 0); #3;
        chk("R3 byte2 masked", reg_rdata, 8'hF0);

        // R10: write not visible until edge
        cyc(1, 8'h00, 8'h77); #3;
        chk("R10 before edge", q_base[31:24], 8'h12);
        cyc(0, 8'h00, 0); #3;
        chk("R10 after edge", q_base[31:24], 8'h77);

        // R4: enables, repeated same value still flushes
        cyc(1, 8'h07, 8'h01);
        cyc(1, 8'h07, 8'h01);
        cyc(1, 8'h0F, 8'hFE);
        cyc(1, 8'h03, 8'h03);
        cyc(0, 8'h07, 0); #3;
        chk("R4 enable read", reg_rdata, 8'h01);
        cyc(0, 8'h07, 0); #3;
        chk("R10 flush one cycle", flush_start, 1'b0);

        // R5/R6: index build, pad byte ignored, clear
        cyc(1, 8'h11, 8'hAB);
        cyc(1, 8'h10, 8'hFF);
        cyc(1, 8'h12, 8'hCF);
        cyc(1, 8'h13, 8'h00);
        cyc(0, 8'h13, 0); #3;
        chk("R6 clear pulse", {slot_clr, slot_idx}, {1'b1, 12'hABC});
        cyc(0, 8'h13, 0); #3;
        chk("R10 clear one cycle", slot_clr, 1'b0);

        // R7, R9: global enable and ignored offsets
        cyc(1, 8'h15, 8'h01);
        cyc(1, 8'h14, 8'hFF);
        cyc(1, 8'h16, 8'hFF);
        cyc(1, 8'hFE, 8'h00);
        cyc(1, 8'h80, 8'h55);
        cyc(0, 8'h00, 0);

        // R8/R9: read sweep over all offsets
        for (int a = 0; a < 256; a++) cyc(0, 8'(a), 8'h00);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic [7:0] a;
            k = $urandom % 24;
            if (k < 16)      a = 8'(k);
            else if (k < 22) a = 8'(8'h10 + k - 16);
            else if (k == 22) a = 8'hFE;
            else             a = 8'($urandom);
            cyc(1'($urandom % 2), a, 8'($urandom));
        end
        cyc(0, 8'h00, 0);
        cyc(0, 8'h00, 0);
        @(negedge clk); #3;
        done = 1;
        finish_run();
    end
endmodule